// File: doc/BRIEF.md
# Alternate-Line Camera Frame Capture

This block receives raw pixels from a parallel image sensor port (pixel clock, line-valid, frame-sync and a 16-bit data word) and turns them into single-word writes on a memory write port running in the system clock domain. The sensor is set up so that it emits every raw line twice. The block therefore stores only every second line-valid period. A rising frame-sync starts a new frame. The line after it is dropped, and from then on lines alternate between stored and dropped.

All sensor signals pass through two-flop synchronizers and are edge-detected in the system clock domain. The sensor gates its pixel clock with line-valid, so a synchronized pixel-clock rise seen while line-valid is high marks one pixel. Stored pixels go to consecutive word addresses, starting from a base address that is loaded at each frame start. A one-cycle done pulse follows the end of the last stored line. A sticky overrun flag records a frame-sync that arrives while a started frame is still incomplete.

Top module: `cam_line_capture`

## Requirements
- R1: After reset `memWrEn`, `frameDone` and `overrun` are 0.
- R2: During a stored line, each pixel-clock rising edge that occurs while line-valid is high produces exactly one write. That write is a single-cycle `memWrEn` pulse with `memData` equal to the sampled pixel word.
- R3: The first line-valid period after a frame-sync rise is dropped (no writes). After it, periods alternate between stored and dropped. The stored/dropped state changes at each line-valid falling edge.
- R4: A frame-sync rise loads `baseAddr` as the next write address. Each stored word goes to the previous address plus one, and the sequence continues across stored lines.
- R5: A stored line writes at most `LINE_PIX` words (default 320). Pixels after that within the same line are dropped.
- R6: At the line-valid falling edge that ends the `FRAME_KEEP`-th stored line (default 120, of 240 periods), `frameDone` pulses for exactly one cycle. After that, no write occurs until the next frame-sync rise.
- R7: `overrun` is set when a frame-sync rise arrives after a frame was started and before its `FRAME_KEEP` lines were stored. It stays set until reset.
- R8: A frame-sync rise in the middle of a frame restarts line tracking: the next period is dropped and the stored-line count starts from zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| camPclk | input | 1 | Sensor pixel clock, asynchronous, active only during line-valid |
| camHref | input | 1 | Sensor line-valid, asynchronous |
| camVsync | input | 1 | Sensor frame-sync, asynchronous, rising edge starts a frame |
| camData | input | PIX_W | Sensor pixel word |
| baseAddr | input | ADDR_W | Word address of the first stored pixel of a frame |
| memWrEn | output | 1 | Write strobe, one cycle per stored pixel |
| memAddr | output | ADDR_W | Write word address |
| memData | output | PIX_W | Write data |
| frameDone | output | 1 | One-cycle pulse when the last stored line of a frame ends |
| overrun | output | 1 | Sticky flag: frame-sync arrived with a frame incomplete |

## Verification
If the line-parity state is wrong, a whole line of writes appears where none is expected, or is missing. The scoreboard shows this at the first pixel of the affected line. A wrong address counter shows up in the address field of the next write. A wrong stored-line count moves `frameDone` to a different line boundary, and the bench finds this at the end of the frame through the number of words written before the pulse. A wrong overrun condition is visible on the sticky flag right after the offending frame-sync.

// File: rtl/cam_capture_pkg.sv
package cam_capture_pkg;
  typedef struct packed {
    logic frameStart;  // load base address
    logic wrPix;       // write the current pixel word
  } capStrobe_t;
endpackage

// File: rtl/cam_input_sync.sv
module cam_input_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/cam_capture_ctrl.sv
module cam_capture_ctrl
  import cam_capture_pkg::*;
#(
  parameter int LINE_PIX   = 320,
  parameter int FRAME_KEEP = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pclkS,
  input  logic       hrefS,
  input  logic       vsyncS,
  output capStrobe_t strobe,
  output logic       frameDone,
  output logic       overrun
);
  localparam int PIX_CW  = $clog2(LINE_PIX + 1);
  localparam int LINE_CW = $clog2(FRAME_KEEP + 1);
  localparam logic [PIX_CW-1:0]  PIX_LIMIT  = PIX_CW'(LINE_PIX);
  localparam logic [LINE_CW-1:0] LINE_LAST  = LINE_CW'(FRAME_KEEP - 1);

  logic pclkPrev, hrefPrev, vsyncPrev;
  logic pclkRise, hrefFall, vsyncRise;
  logic keepLine, frameOpen;
  logic [PIX_CW-1:0]  pixCnt;
  logic [LINE_CW-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pclkPrev  <= 1'b0;
      hrefPrev  <= 1'b0;
      vsyncPrev <= 1'b0;
    end else begin
      pclkPrev  <= pclkS;
      hrefPrev  <= hrefS;
      vsyncPrev <= vsyncS;
    end
  end

  assign pclkRise  = pclkS & ~pclkPrev;
  assign hrefFall  = ~hrefS & hrefPrev;
  assign vsyncRise = vsyncS & ~vsyncPrev;

  always_comb begin
    strobe.frameStart = vsyncRise;
    strobe.wrPix = ~vsyncRise & pclkRise & hrefS & keepLine & frameOpen
                   & (pixCnt < PIX_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keepLine  <= 1'b0;
      frameOpen <= 1'b0;
      pixCnt    <= '0;
      lineCnt   <= '0;
      frameDone <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (vsyncRise) begin
        if (frameOpen) overrun <= 1'b1;
        keepLine  <= 1'b0;
        frameOpen <= 1'b1;
        pixCnt    <= '0;
        lineCnt   <= '0;
      end else if (hrefFall) begin
        pixCnt   <= '0;
        keepLine <= ~keepLine;
        if (frameOpen && keepLine) begin
          if (lineCnt == LINE_LAST) begin
            frameDone <= 1'b1;
            frameOpen <= 1'b0;
            lineCnt   <= '0;
          end else begin
            lineCnt <= lineCnt + 1'b1;
          end
        end
      end else if (strobe.wrPix) begin
        pixCnt <= pixCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_capture_dp.sv
module cam_capture_dp
  import cam_capture_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  capStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [PIX_W-1:0]  pixData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PIX_W-1:0]  memData
);
  logic [ADDR_W-1:0] addrNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrNext <= '0;
      memWrEn  <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
    end else begin
      memWrEn <= strobe.wrPix;
      if (strobe.frameStart) begin
        addrNext <= baseAddr;
      end else if (strobe.wrPix) begin
        memAddr  <= addrNext;
        memData  <= pixData;
        addrNext <= addrNext + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_line_capture.sv
module cam_line_capture
  import cam_capture_pkg::*;
#(
  parameter int PIX_W      = 16,
  parameter int ADDR_W     = 20,
  parameter int LINE_PIX   = 320,
  parameter int FRAME_KEEP = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              camPclk,
  input  logic              camHref,
  input  logic              camVsync,
  input  logic [PIX_W-1:0]  camData,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PIX_W-1:0]  memData,
  output logic              frameDone,
  output logic              overrun
);
  localparam int SYNC_W = PIX_W + 3;

  logic [SYNC_W-1:0] syncIn, syncOut;
  capStrobe_t strobe;

  assign syncIn = {camPclk, camHref, camVsync, camData};

  cam_input_sync #(.WIDTH(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .asyncIn(syncIn), .syncOut(syncOut)
  );

  cam_capture_ctrl #(.LINE_PIX(LINE_PIX), .FRAME_KEEP(FRAME_KEEP)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pclkS(syncOut[PIX_W+2]), .hrefS(syncOut[PIX_W+1]), .vsyncS(syncOut[PIX_W]),
    .strobe(strobe), .frameDone(frameDone), .overrun(overrun)
  );

  cam_capture_dp #(.PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .baseAddr(baseAddr),
    .pixData(syncOut[PIX_W-1:0]),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/cam_capture_checker.sv
module cam_capture_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frameStart,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              frameDone,
  input logic              overrun
);
  logic [ADDR_W-1:0] prevAddr;
  logic seenWr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevAddr <= '0;
      seenWr   <= 1'b0;
    end else if (frameStart) begin
      seenWr <= 1'b0;
    end else if (memWrEn) begin
      prevAddr <= memAddr;
      seenWr   <= 1'b1;
    end
  end

  // R2: one write cycle per pixel-clock rise
  assert_single_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |=> !memWrEn);

  // R4: consecutive writes within a frame step the address by one
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrEn && seenWr) |-> memAddr == prevAddr + 1'b1);

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone);

  // R6: no write follows done in the next cycle
  assert_no_write_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !memWrEn);

  // R7: overrun never clears outside reset
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind cam_line_capture cam_capture_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frameStart(strobe.frameStart),
  .memWrEn(memWrEn), .memAddr(memAddr), .frameDone(frameDone), .overrun(overrun)
);

// File: tb/cam_line_capture_tb.sv
module cam_line_capture_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 16;
  localparam int ADDR_W = 16;
  localparam int LINE_PIX = 6;
  localparam int FRAME_KEEP = 3;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic camPclk = 1'b0, camHref = 1'b0, camVsync = 1'b0;
  logic [PIX_W-1:0] camData = '0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic memWrEn, frameDone, overrun;
  logic [ADDR_W-1:0] memAddr;
  logic [PIX_W-1:0] memData;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_line_capture #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .LINE_PIX(LINE_PIX),
                     .FRAME_KEEP(FRAME_KEEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .camPclk(camPclk), .camHref(camHref),
    .camVsync(camVsync), .camData(camData), .baseAddr(baseAddr),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .frameDone(frameDone), .overrun(overrun)
  );

  int checks = 0, fails = 0;
  logic [ADDR_W+PIX_W-1:0] expQ[$];
  logic [ADDR_W-1:0] expAddr;
  int wordsInFrame = 0, doneCount = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && memWrEn) begin
      wordsInFrame++;
      if (expQ.size() == 0) begin
        check(0, "R3 unexpected write", int'(memAddr), 0);
      end else begin
        logic [ADDR_W+PIX_W-1:0] e;
        e = expQ.pop_front();
        check({memAddr, memData} == e, "R2/R4 write", int'({memAddr, memData}), int'(e));
      end
    end
    if (rst_n && frameDone) begin
      doneCount++;
      check(wordsInFrame == FRAME_KEEP*LINE_PIX, "R6 words before done",
            wordsInFrame, FRAME_KEEP*LINE_PIX);
      check(expQ.size() == 0, "R6 queue empty at done", expQ.size(), 0);
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      check(0, "watchdog", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frameSync(logic [ADDR_W-1:0] base);
    baseAddr = base;
    expAddr = base;
    wordsInFrame = 0;
    waitClk(1);
    camVsync = 1'b1;
    waitClk(8);
    camVsync = 1'b0;
    waitClk(8);
  endtask

  task automatic sendLine(int nPix, bit kept, int seed);
    camHref = 1'b1;
    waitClk(4);
    for (int p = 0; p < nPix; p++) begin
      logic [PIX_W-1:0] v;
      v = PIX_W'(seed * 64 + p * 3 + 1);
      camData = v;
      if (kept && p < LINE_PIX) begin
        expQ.push_back({expAddr, v});
        expAddr = expAddr + 1'b1;
      end
      waitClk(3);
      camPclk = 1'b1;
      waitClk(3);
      camPclk = 1'b0;
    end
    waitClk(3);
    camHref = 1'b0;
    waitClk(10);
  endtask

  initial begin
    waitClk(3);
    rst_n = 1'b1;
    waitClk(1);
    // R1 reset state
    check(memWrEn == 0, "R1 memWrEn", memWrEn, 0);
    check(frameDone == 0, "R1 frameDone", frameDone, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);

    // Frame 1: full frame, R2 R3 R4 R6
    frameSync(16'h0100);
    for (int l = 0; l < 2*FRAME_KEEP; l++) sendLine(LINE_PIX, l % 2 == 1, 10 + l);
    waitClk(4);
    check(doneCount == 1, "R6 done count frame1", doneCount, 1);
    check(overrun == 0, "R7 no overrun on full frame", overrun, 0);
    // after done: a line produces no write (R6)
    sendLine(LINE_PIX, 0, 40);
    check(expQ.size() == 0, "R6 no write after done", expQ.size(), 0);

    // Frame 2: over-long stored line truncated (R5), new base (R4)
    frameSync(16'h2000);
    for (int l = 0; l < 2*FRAME_KEEP; l++)
      sendLine((l == 1) ? LINE_PIX + 2 : LINE_PIX, l % 2 == 1, 50 + l);
    waitClk(4);
    check(doneCount == 2, "R5/R6 done count frame2", doneCount, 2);
    check(wordsInFrame == FRAME_KEEP*LINE_PIX, "R5 truncated word count",
          wordsInFrame, FRAME_KEEP*LINE_PIX);

    // Partial frame then early frame-sync: R7, R8
    frameSync(16'h3000);
    sendLine(LINE_PIX, 0, 70);
    sendLine(LINE_PIX, 1, 71);
    check(overrun == 0, "R7 overrun not yet", overrun, 0);
    frameSync(16'h0040);
    check(overrun == 1, "R7 overrun set", overrun, 1);
    for (int l = 0; l < 2*FRAME_KEEP; l++) sendLine(LINE_PIX, l % 2 == 1, 80 + l);
    waitClk(4);
    check(doneCount == 3, "R8 done after restarted frame", doneCount, 3);
    check(overrun == 1, "R7 overrun sticky", overrun, 1);
    check(expQ.size() == 0, "R3 all expected writes seen", expQ.size(), 0);
    finish_run();
  end
endmodule